// File: doc/BRIEF.md
# CSR Read-Modify-Write Execute Unit

This unit sits in the execute stage of a processor pipeline and carries out the arithmetic of the six control-and-status-register instructions. It receives the instruction word, the source register data, the current value of the addressed CSR and a slot-valid qualifier. From these it works out the replacement CSR value, a write enable and the CSR address. It also flags whether the slot is a CSR access at all, and passes the old CSR value through as the destination register result. All outputs are registered once, so results appear one clock after the inputs are presented.

The unit applies the architectural write-suppression rule. The set and clear forms become pure reads when their source register index is zero (register form) or their 5-bit immediate is zero (immediate form). This avoids write side effects on registers that are read-only. The CSR storage, the decoding of individual CSR addresses and all trap handling belong to neighbouring blocks.

Top module: `csr_rmw_unit`

## Requirements
- R1: For funct3 001 (register write) and 101 (immediate write) the write enable is 1 and the new value equals the operand, including when the operand is zero or the source index is zero.
- R2: For funct3 010 and 110 (set forms) the new value is the old value OR the operand.
- R3: For funct3 011 and 111 (clear forms) the new value is the old value AND the bitwise inverse of the operand.
- R4: When funct3 bit 2 is 1 the operand is instruction bits 19:15 zero-extended to the data width. When funct3 bit 2 is 0 the operand is the rs1 data.
- R5: Register set and clear forms (funct3 010, 011) whose source index (bits 19:15) is 0 leave the write enable at 0.
- R6: Immediate set and clear forms (funct3 110, 111) whose immediate (bits 19:15) is 0 leave the write enable at 0.
- R7: The destination result equals the old CSR value presented with the instruction.
- R8: The CSR address output equals instruction bits 31:20.
- R9: An instruction whose opcode (bits 6:0) is not 1110011, or whose funct3 is 000 or 100, gives a CSR flag of 0 and a write enable of 0.
- R10: When the valid input is 0, the CSR flag and the write enable are 0.
- R11: Every output shows the result of the inputs sampled at the preceding rising clock edge. While reset (active low) is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Slot carries a live instruction |
| in_instr | input | 32 | Instruction word |
| in_rs1_data | input | XLEN | Source register value |
| in_old_val | input | XLEN | Current value of the addressed CSR |
| out_valid | output | 1 | Registered slot valid |
| out_is_csr | output | 1 | Slot is a live CSR instruction |
| out_csr_we | output | 1 | CSR write enable |
| out_csr_addr | output | 12 | CSR address |
| out_csr_wdata | output | XLEN | New CSR value |
| out_rd_data | output | XLEN | Result for the destination register |

## Verification
The hardest case to reach is the boundary between suppression and writing. An index or immediate of exactly zero must block the set and clear forms but must not block the write forms. Uniformly random 5-bit fields hit zero only rarely. The random stimulus therefore draws the source field as zero about a third of the time and pairs it with every funct3 value. Directed cases add all-ones operands, zero operands on the write forms, and squashed slots that carry otherwise legal CSR instructions.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = 12;
  localparam int INSTR_W = 32;
  localparam logic [6:0] SYSTEM_OPC = 7'b1110011;

  // low two funct3 bits select the operation kind
  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_WRITE = 2'b01,
    K_SET   = 2'b10,
    K_CLEAR = 2'b11
  } csr_kind_e;

  typedef struct packed {
    logic              is_csr;
    csr_kind_e         kind;
    logic              use_imm;
    logic [IDX_W-1:0]  src_idx;
    logic [ADDR_W-1:0] addr;
  } csr_dec_t;
endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
  import csr_rmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output csr_dec_t           dec,
  output logic               suppress,
  output logic               wr_req
);
  logic [6:0]        opc;
  logic [2:0]        f3;
  logic              legal;

  assign opc = in_instr[6:0];
  assign f3  = in_instr[14:12];

  always_comb begin
    legal        = in_valid && (opc == SYSTEM_OPC) && (f3[1:0] != 2'b00);
    dec.is_csr   = legal;
    dec.kind     = legal ? csr_kind_e'(f3[1:0]) : K_NONE;
    dec.use_imm  = f3[2];
    dec.src_idx  = in_instr[19:15];
    dec.addr     = in_instr[31:20];
    suppress     = legal && (dec.kind != K_WRITE) && (dec.src_idx == '0);
    wr_req       = legal && !suppress;
  end

  // R10
  squash_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!wr_req && !dec.is_csr));
  // R5
  suppress_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> !wr_req);
  // R1
  write_form_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.is_csr && dec.kind == K_WRITE) |-> wr_req);
endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  csr_kind_e        kind,
  input  logic             use_imm,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]  rs1_data,
  input  logic [XLEN-1:0]  old_val,
  output logic [XLEN-1:0]  operand,
  output logic [XLEN-1:0]  new_val
);
  function automatic logic [XLEN-1:0] pick_operand(
    input logic imm, input logic [IDX_W-1:0] idx, input logic [XLEN-1:0] reg_val);
    logic [XLEN-1:0] z;
    z = '0;
    z[IDX_W-1:0] = idx;
    return imm ? z : reg_val;
  endfunction

  function automatic logic [XLEN-1:0] merge(
    input csr_kind_e k, input logic [XLEN-1:0] old, input logic [XLEN-1:0] op);
    case (k)
      K_WRITE: return op;
      K_SET:   return old | op;
      K_CLEAR: return old & ~op;
      default: return old;
    endcase
  endfunction

  assign operand = pick_operand(use_imm, src_idx, rs1_data);
  assign new_val = merge(kind, old_val, operand);

  // R2
  set_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SET) |-> ((new_val & old_val) == old_val));
  // R3
  clear_adds_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CLEAR) |-> ((new_val & ~old_val) == '0));
  // R4
  imm_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_imm |-> (operand[XLEN-1:IDX_W] == '0));
endmodule

// File: rtl/csr_rmw_outreg.sv
module csr_rmw_outreg
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic              d_is_csr,
  input  logic              d_we,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [XLEN-1:0]   d_wdata,
  input  logic [XLEN-1:0]   d_rd,
  output logic              q_valid,
  output logic              q_is_csr,
  output logic              q_we,
  output logic [ADDR_W-1:0] q_addr,
  output logic [XLEN-1:0]   q_wdata,
  output logic [XLEN-1:0]   q_rd
);
  logic primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_is_csr <= 1'b0;
      q_we     <= 1'b0;
      q_addr   <= '0;
      q_wdata  <= '0;
      q_rd     <= '0;
      primed   <= 1'b0;
    end else begin
      q_valid  <= d_valid;
      q_is_csr <= d_is_csr;
      q_we     <= d_we;
      q_addr   <= d_addr;
      q_wdata  <= d_wdata;
      q_rd     <= d_rd;
      primed   <= 1'b1;
    end
  end

  // R9
  we_implies_csr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_we |-> (q_is_csr && q_valid));
  // R7
  rd_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (q_rd == $past(d_rd)));
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        in_instr,
  input  logic [XLEN-1:0]    in_rs1_data,
  input  logic [XLEN-1:0]    in_old_val,
  output logic               out_valid,
  output logic               out_is_csr,
  output logic               out_csr_we,
  output logic [11:0]        out_csr_addr,
  output logic [XLEN-1:0]    out_csr_wdata,
  output logic [XLEN-1:0]    out_rd_data
);
  csr_dec_t         dec;
  logic             dec_suppress;
  logic             dec_wr_req;
  logic [XLEN-1:0]  alu_operand;
  logic [XLEN-1:0]  alu_new;

  csr_rmw_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_instr (in_instr),
    .dec      (dec),
    .suppress (dec_suppress),
    .wr_req   (dec_wr_req)
  );

  csr_rmw_alu #(.XLEN(XLEN)) u_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (dec.kind),
    .use_imm  (dec.use_imm),
    .src_idx  (dec.src_idx),
    .rs1_data (in_rs1_data),
    .old_val  (in_old_val),
    .operand  (alu_operand),
    .new_val  (alu_new)
  );

  csr_rmw_outreg #(.XLEN(XLEN)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_valid  (in_valid),
    .d_is_csr (dec.is_csr),
    .d_we     (dec_wr_req),
    .d_addr   (dec.addr),
    .d_wdata  (alu_new),
    .d_rd     (in_old_val),
    .q_valid  (out_valid),
    .q_is_csr (out_is_csr),
    .q_we     (out_csr_we),
    .q_addr   (out_csr_addr),
    .q_wdata  (out_csr_wdata),
    .q_rd     (out_rd_data)
  );

  // R6
  imm_zero_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.is_csr && dec.use_imm && dec.kind != K_WRITE && in_instr[19:15] == '0)
      |-> !dec_wr_req);
  // R1
  write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == K_WRITE) |-> (alu_new == alu_operand));
endmodule

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;
  localparam int XLEN = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [XLEN-1:0] in_rs1_data = '0, in_old_val = '0;
  logic out_valid, out_is_csr, out_csr_we;
  logic [11:0] out_csr_addr;
  logic [XLEN-1:0] out_csr_wdata, out_rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csr_rmw_unit #(.XLEN(XLEN)) dut (.*);

  function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] idx,
                                     input logic [2:0] f3, input logic [6:0] opc);
    return {a, idx, f3, 5'd7, opc};
  endfunction

  function automatic bit exp_csr(input bit v, input logic [31:0] ins);
    return v && ins[6:0] == 7'h73 && ins[13:12] != 2'b00;
  endfunction

  function automatic bit exp_we(input bit v, input logic [31:0] ins);
    if (!exp_csr(v, ins)) return 0;
    if (ins[13:12] == 2'b01) return 1;
    return ins[19:15] != 5'd0;
  endfunction

  function automatic logic [XLEN-1:0] exp_new(input logic [31:0] ins,
      input logic [XLEN-1:0] rs1, input logic [XLEN-1:0] old);
    logic [XLEN-1:0] src;
    src = ins[14] ? XLEN'(ins[19:15]) : rs1;
    if (ins[13:12] == 2'b01) return src;
    if (ins[13:12] == 2'b10) return src | old;
    return ~(~old | src);
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit v, input logic [31:0] ins,
                     input logic [XLEN-1:0] rs1, input logic [XLEN-1:0] old, input string req);
    bit ev, ew;
    @(negedge clk);
    in_valid = v; in_instr = ins; in_rs1_data = rs1; in_old_val = old;
    ev = exp_csr(v, ins);
    ew = exp_we(v, ins);
    @(negedge clk);
    chk({req, " R11 valid"}, XLEN'(out_valid), XLEN'(v));
    chk({req, " R9 R10 is_csr"}, XLEN'(out_is_csr), XLEN'(ev));
    chk({req, " R5 R6 R10 we"}, XLEN'(out_csr_we), XLEN'(ew));
    chk({req, " R7 rd"}, out_rd_data, old);
    chk({req, " R8 addr"}, XLEN'(out_csr_addr), XLEN'(ins[31:20]));
    if (ew) chk({req, " R2 R3 R4 wdata"}, out_csr_wdata, exp_new(ins, rs1, old));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    in_valid = 1'b1;
    in_instr = mk(12'h300, 5'd3, 3'b001, 7'h73);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset valid", XLEN'(out_valid), '0);
    chk("R11 reset we", XLEN'(out_csr_we), '0);
    chk("R11 reset wdata", out_csr_wdata, '0);
    rst_n = 1'b1;
    // directed
    run(1, mk(12'h305, 5'd0, 3'b001, 7'h73), '0, 32'hFFFF_FFFF, "R1 write zero x0");
    chk("R1 wdata zero", out_csr_wdata, '0);
    run(1, mk(12'h340, 5'd0, 3'b101, 7'h73), 32'hDEAD_BEEF, 32'h1234_5678, "R1 imm write zero");
    chk("R1 imm wdata zero", out_csr_wdata, '0);
    run(1, mk(12'h341, 5'd9, 3'b010, 7'h73), 32'h0F0F_0000, 32'h0000_00F0, "R2 set reg");
    chk("R2 set value", out_csr_wdata, 32'h0F0F_00F0);
    run(1, mk(12'h342, 5'd9, 3'b011, 7'h73), 32'hFFFF_0000, 32'h1234_5678, "R3 clear reg");
    chk("R3 clear value", out_csr_wdata, 32'h0000_5678);
    run(1, mk(12'h300, 5'h1F, 3'b110, 7'h73), 32'hFFFF_FFFF, 32'h8000_0000, "R4 imm set");
    chk("R4 imm set value", out_csr_wdata, 32'h8000_001F);
    run(1, mk(12'h300, 5'h08, 3'b111, 7'h73), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 imm clear");
    chk("R4 imm clear value", out_csr_wdata, 32'hFFFF_FFF7);
    run(1, mk(12'hB00, 5'd0, 3'b010, 7'h73), 32'hFFFF_FFFF, 32'hAAAA_5555, "R5 set x0");
    run(1, mk(12'hB80, 5'd0, 3'b011, 7'h73), 32'hFFFF_FFFF, 32'hAAAA_5555, "R5 clear x0");
    run(1, mk(12'h344, 5'd0, 3'b110, 7'h73), '0, 32'h0000_0888, "R6 imm set zero");
    run(1, mk(12'h344, 5'd0, 3'b111, 7'h73), '0, 32'h0000_0888, "R6 imm clear zero");
    run(1, mk(12'h300, 5'd4, 3'b000, 7'h73), 32'h1, 32'h2, "R9 funct3 000");
    run(1, mk(12'h300, 5'd4, 3'b100, 7'h73), 32'h1, 32'h2, "R9 funct3 100");
    run(1, mk(12'h300, 5'd4, 3'b001, 7'h33), 32'h1, 32'h2, "R9 other opcode");
    run(0, mk(12'h300, 5'd4, 3'b001, 7'h73), 32'h1, 32'h2, "R10 squashed write");
    run(0, mk(12'h300, 5'd4, 3'b110, 7'h73), 32'h1, 32'h2, "R10 squashed set");
    // random
    for (int i = 0; i < 600; i++) begin
      logic [4:0] idx;
      logic [6:0] opc;
      idx = ($urandom_range(2) == 0) ? 5'd0 : 5'($urandom);
      opc = ($urandom_range(7) == 0) ? 7'($urandom) : 7'h73;
      run($urandom_range(5) != 0, mk(12'($urandom), idx, 3'($urandom), opc),
          $urandom, $urandom, "random R1 R2 R3");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule